// File: doc/BRIEF.md
# Indexed Register Window for a Disc Data Controller

This block is the host's view into the registers of an optical-disc data controller. The host has two addresses. Address 0 holds a 4-bit index. Address 1 is a data port that reaches whichever internal register the index selects. Every data-port access moves the index forward by one, so a burst of accesses walks through consecutive registers with no extra index writes. Reads and writes use different maps behind the same index.

The window stores the 16-bit transfer byte count, the transfer data address, the write address and the block pointer, each written one byte at a time. It also stores the interface control byte and two control bytes. It keeps the interface status byte, which holds the active-low pending flags. It reads back the header bytes from one of two banks, and the status bytes supplied by the decoder. Writes to the trigger and acknowledge indices reach the transfer engine as single-cycle strobes. The controller's interrupt leaves the block as a single-cycle pulse.

Top module: `disc_reg_window`

## Requirements
- R1: A data-port access (cs with addr=1, and rd or wr) moves the index to index+1 on the next cycle, wrapping from 0xF to 0x0. A write at addr=0 loads the index from wdata[3:0]. A read at addr=0 returns {4'h0, index} and leaves the index unchanged.
- R2: While rst_n is low at a clock edge, the block resets. The index becomes 0 and the interface status becomes 0xFF. All stored registers, rdata, trig, ack and irq become 0.
- R3: The write map is as follows. 1 loads interface control. 2/3 load the byte count low/high. 4/5 load the data address low/high. 8/9 load the write address low/high. 0xA loads control 0 and 0xB loads control 1. 0xC/0xD load the block pointer low/high.
- R4: A write to a low or high byte index changes only that byte of its 16-bit register and keeps the other byte.
- R5: The read map is as follows. 0 gives 0x00 and 1 gives interface status. 2/3 give the byte count low/high. 8/9 give the block pointer low/high, and 0xA/0xB give the write address low/high. 0xC gives status0, 0xD always gives 0x00, 0xE gives status2 and 0xF gives status3. Read data appears on rdata the cycle after the read and is held until the next read.
- R6: Reads at indices 4 to 7 return header bytes 0 to 3. Byte k is bits [8k+7:8k] of hdr_bank0, or of hdr_bank1 when bit 0 of control 1 is set.
- R7: A write at index 6 gives a one-cycle trig pulse, and a write at index 7 gives a one-cycle ack pulse. Neither write stores data. The ack write also sets interface status bit 6 (transfer-end flag, active low) back to 1.
- R8: dec_evt clears interface status bit 5 (decoder flag, active low), and dte_evt clears bit 6. An event gives an irq pulse on the next cycle only when its enable is set: interface control bit 5 for the decoder, bit 6 for transfer end.
- R9: A write to interface control gives an irq pulse on the next cycle if it newly sets an enable bit (5 or 6) whose flag is already pending (0). Writing an enable that is already set gives no pulse.
- R10: A write at index 0xF is a soft reset. It sets interface status to 0xFF and clears interface control, control 0 and control 1, while the index still wraps to 0. Writes at indices 0 and 0xE change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select |
| addr | input | 1 | 0 = index register, 1 = data port |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| dec_evt | input | 1 | Decoder event from the engine |
| dte_evt | input | 1 | Transfer-end event from the engine |
| hdr_bank0 | input | 32 | Header bank 0, byte k in bits [8k+7:8k] |
| hdr_bank1 | input | 32 | Header bank 1, byte k in bits [8k+7:8k] |
| status0 | input | 8 | Status byte 0 |
| status2 | input | 8 | Status byte 2 |
| status3 | input | 8 | Status byte 3 |
| trig | output | 1 | Transfer-trigger strobe |
| ack | output | 1 | Transfer-end acknowledge strobe |
| irq | output | 1 | Interrupt pulse |
| byte_cnt | output | 16 | Transfer byte count |
| data_addr | output | 16 | Transfer data address |
| wr_addr | output | 16 | Write address |
| blk_ptr | output | 16 | Block pointer |
| if_ctrl | output | 8 | Interface control |
| ctrl0 | output | 8 | Control 0 |
| ctrl1 | output | 8 | Control 1 |

## Verification
The assertions assume that the host never asserts rd and wr in the same cycle. The index-step property counts a simultaneous read and write as one access. The pulse properties also assume that the engine events arrive in isolation. To keep within these limits, the stimulus tasks drive one strobe per access and return the bus to idle for one cycle after each access. Events are driven only while the bus is idle.

// File: rtl/disc_reg_window.sv
module disc_reg_window #(
  parameter int DW = 8,
  parameter int IW = 4,
  parameter int HB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic               dec_evt,
  input  logic               dte_evt,
  input  logic [HB*DW-1:0]   hdr_bank0,
  input  logic [HB*DW-1:0]   hdr_bank1,
  input  logic [DW-1:0]      status0,
  input  logic [DW-1:0]      status2,
  input  logic [DW-1:0]      status3,
  output logic               trig,
  output logic               ack,
  output logic               irq,
  output logic [2*DW-1:0]    byte_cnt,
  output logic [2*DW-1:0]    data_addr,
  output logic [2*DW-1:0]    wr_addr,
  output logic [2*DW-1:0]    blk_ptr,
  output logic [DW-1:0]      if_ctrl,
  output logic [DW-1:0]      ctrl0,
  output logic [DW-1:0]      ctrl1
);
  localparam int DECB = 5;
  localparam int DTEB = 6;

  logic [IW-1:0]    idx;
  logic [DW-1:0]    ifstat;
  logic [DW-1:0]    rmux;
  logic [HB*DW-1:0] hsel;

  wire dat_wr  = cs && addr && wr;
  wire dat_rd  = cs && addr && rd;
  wire dat_acc = dat_wr || dat_rd;
  wire idx_wr  = cs && !addr && wr;
  wire idx_rd  = cs && !addr && rd;

  wire ctl_wr  = dat_wr && idx == IW'(1);
  wire arm_irq = ctl_wr &&
                 ((wdata[DECB] && !if_ctrl[DECB] && !ifstat[DECB]) ||
                  (wdata[DTEB] && !if_ctrl[DTEB] && !ifstat[DTEB]));
  wire evt_irq = (dec_evt && if_ctrl[DECB]) || (dte_evt && if_ctrl[DTEB]);

  assign hsel = ctrl1[0] ? hdr_bank1 : hdr_bank0;

  always_comb begin
    rmux = '0;
    case (idx)
      4'h1: rmux = ifstat;
      4'h2: rmux = byte_cnt[DW-1:0];
      4'h3: rmux = byte_cnt[2*DW-1:DW];
      4'h4, 4'h5, 4'h6, 4'h7: rmux = hsel[idx[1:0]*DW +: DW];
      4'h8: rmux = blk_ptr[DW-1:0];
      4'h9: rmux = blk_ptr[2*DW-1:DW];
      4'hA: rmux = wr_addr[DW-1:0];
      4'hB: rmux = wr_addr[2*DW-1:DW];
      4'hC: rmux = status0;
      4'hE: rmux = status2;
      4'hF: rmux = status3;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      ifstat    <= '1;
      if_ctrl   <= '0;
      ctrl0     <= '0;
      ctrl1     <= '0;
      byte_cnt  <= '0;
      data_addr <= '0;
      wr_addr   <= '0;
      blk_ptr   <= '0;
      rdata     <= '0;
      trig      <= 1'b0;
      ack       <= 1'b0;
      irq       <= 1'b0;
    end else begin
      trig <= 1'b0;
      ack  <= 1'b0;
      irq  <= evt_irq || arm_irq;
      if (dec_evt) ifstat[DECB] <= 1'b0;
      if (dte_evt) ifstat[DTEB] <= 1'b0;
      if (idx_wr)  idx <= wdata[IW-1:0];
      if (dat_acc) idx <= idx + 1'b1;
      if (dat_rd)      rdata <= rmux;
      else if (idx_rd) rdata <= {{(DW-IW){1'b0}}, idx};
      if (dat_wr) begin
        case (idx)
          4'h1: if_ctrl <= wdata;
          4'h2: byte_cnt[DW-1:0]     <= wdata;
          4'h3: byte_cnt[2*DW-1:DW]  <= wdata;
          4'h4: data_addr[DW-1:0]    <= wdata;
          4'h5: data_addr[2*DW-1:DW] <= wdata;
          4'h6: trig <= 1'b1;
          4'h7: begin
            ack          <= 1'b1;
            ifstat[DTEB] <= 1'b1;
          end
          4'h8: wr_addr[DW-1:0]      <= wdata;
          4'h9: wr_addr[2*DW-1:DW]   <= wdata;
          4'hA: ctrl0 <= wdata;
          4'hB: ctrl1 <= wdata;
          4'hC: blk_ptr[DW-1:0]      <= wdata;
          4'hD: blk_ptr[2*DW-1:DW]   <= wdata;
          4'hF: begin
            ifstat  <= '1;
            if_ctrl <= '0;
            ctrl0   <= '0;
            ctrl1   <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    dat_acc |=> idx == $past(idx) + 1'b1);

  a_r2_status_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ifstat == '1 && !irq && !trig);

  a_r4_low_byte_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx == 4'h2) |=> byte_cnt[2*DW-1:DW] == $past(byte_cnt[2*DW-1:DW]));

  a_r5_status1_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && idx == 4'hD) |=> rdata == '0);

  a_r7_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  a_r7_ack_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && (idx == 4'h6 || idx == 4'h7)) |=> $stable(byte_cnt) && $stable(data_addr));

  a_r9_arm_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[DTEB] && !if_ctrl[DTEB] && !ifstat[DTEB]) |=> irq);
endmodule

// File: tb/tb_disc_reg_window.sv
module tb_disc_reg_window;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, addr = 0, rd = 0, wr = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic dec_evt = 0, dte_evt = 0;
  logic [31:0] hdr_bank0 = 32'h44332211;
  logic [31:0] hdr_bank1 = 32'h88776655;
  logic [7:0] status0 = 8'hA1, status2 = 8'hA2, status3 = 8'hA3;
  logic trig, ack, irq;
  logic [15:0] byte_cnt, data_addr, wr_addr, blk_ptr;
  logic [7:0] if_ctrl, ctrl0, ctrl1;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  disc_reg_window dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .dec_evt(dec_evt), .dte_evt(dte_evt),
    .hdr_bank0(hdr_bank0), .hdr_bank1(hdr_bank1),
    .status0(status0), .status2(status2), .status3(status3),
    .trig(trig), .ack(ack), .irq(irq),
    .byte_cnt(byte_cnt), .data_addr(data_addr), .wr_addr(wr_addr),
    .blk_ptr(blk_ptr), .if_ctrl(if_ctrl), .ctrl0(ctrl0), .ctrl1(ctrl1)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(logic a, logic r, logic w, logic [7:0] d);
    @(negedge clk);
    cs = 1; addr = a; rd = r; wr = w; wdata = d;
    @(negedge clk);
    cs = 0; rd = 0; wr = 0;
  endtask

  task automatic set_idx(logic [3:0] i);
    bus(1'b0, 1'b0, 1'b1, {4'h0, i});
  endtask

  task automatic wdat(logic [7:0] d);
    bus(1'b1, 1'b0, 1'b1, d);
  endtask

  task automatic rdat(string req, logic [7:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus(1'b1, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic ridx(string req, logic [3:0] exp);
    exp_q.push_back({4'h0, exp});
    tag_q.push_back(req);
    bus(1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic pulse_evt(bit dec);
    @(negedge clk);
    if (dec) dec_evt = 1; else dte_evt = 1;
    @(negedge clk);
    dec_evt = 0; dte_evt = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cs && rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard read with no expected item actual=%0h expected=none", rdata);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, {24'h0, rdata}, {24'h0, e});
        end
      end
    end
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 byte_cnt", byte_cnt, 0);
    check("R2 if_ctrl", if_ctrl, 0);
    check("R2 irq/trig/ack", {irq, trig, ack}, 0);
    check("R2 rdata", rdata, 0);
    ridx("R2 index", 4'h0);
    set_idx(4'h1);
    rdat("R2 ifstat", 8'hFF);

    wdat(8'h34); wdat(8'h12);
    check("R3 byte_cnt", byte_cnt, 16'h1234);
    ridx("R1 index after two writes", 4'h4);
    wdat(8'h78); wdat(8'h56);
    check("R3 data_addr", data_addr, 16'h5678);
    wdat(8'h99);
    check("R7 trig pulse", {trig, ack}, 2'b10);
    wdat(8'h42);
    check("R7 ack pulse", {trig, ack}, 2'b01);
    check("R7 no store", {byte_cnt, data_addr}, 32'h12345678);
    wdat(8'hCD); wdat(8'hAB);
    check("R3 wr_addr", wr_addr, 16'hABCD);
    wdat(8'h5A); wdat(8'h00);
    check("R3 ctrl0/ctrl1", {ctrl0, ctrl1}, 16'h5A00);
    wdat(8'hEF); wdat(8'hBE);
    check("R3 blk_ptr", blk_ptr, 16'hBEEF);
    wdat(8'hFF);
    check("R10 index E no effect", {if_ctrl, ctrl0, ctrl1, byte_cnt}, 40'h005A001234);
    ridx("R1 index at F", 4'hF);

    set_idx(4'h3); wdat(8'hAB);
    check("R4 high byte only", byte_cnt, 16'hAB34);
    set_idx(4'hC); wdat(8'h11);
    check("R4 low byte only", blk_ptr, 16'hBE11);

    set_idx(4'h2);
    rdat("R5 cnt lo", 8'h34); rdat("R5 cnt hi", 8'hAB);
    rdat("R6 hdr0 b0", 8'h11); rdat("R6 hdr0 b1", 8'h22);
    rdat("R6 hdr0 b2", 8'h33); rdat("R6 hdr0 b3", 8'h44);
    rdat("R5 ptr lo", 8'h11); rdat("R5 ptr hi", 8'hBE);
    rdat("R5 wa lo", 8'hCD); rdat("R5 wa hi", 8'hAB);
    rdat("R5 status0", 8'hA1); rdat("R5 status1 zero", 8'h00);
    rdat("R5 status2", 8'hA2); rdat("R5 status3", 8'hA3);
    rdat("R5 index 0 zero", 8'h00);
    rdat("R5 ifstat", 8'hFF);
    ridx("R1 wrap", 4'h2);

    set_idx(4'hB); wdat(8'h01);
    set_idx(4'h4);
    rdat("R6 hdr1 b0", 8'h55); rdat("R6 hdr1 b1", 8'h66);
    rdat("R6 hdr1 b2", 8'h77); rdat("R6 hdr1 b3", 8'h88);

    pulse_evt(1'b0);
    check("R8 dte no enable irq", irq, 0);
    set_idx(4'h1); rdat("R8 dte flag", 8'hBF);
    set_idx(4'h1); wdat(8'h40);
    check("R9 arm pending irq", irq, 1);
    set_idx(4'h1); wdat(8'h40);
    check("R9 re-arm no irq", irq, 0);
    pulse_evt(1'b0);
    check("R8 dte enabled irq", irq, 1);
    set_idx(4'h7); wdat(8'h00);
    set_idx(4'h1); rdat("R7 ack clears flag", 8'hFF);
    pulse_evt(1'b1);
    check("R8 dec no enable irq", irq, 0);
    set_idx(4'h1); rdat("R8 dec flag", 8'hDF);
    set_idx(4'h1); wdat(8'h60);
    check("R9 arm dec irq", irq, 1);

    set_idx(4'hF); wdat(8'h00);
    check("R10 soft reset ctrl", {if_ctrl, ctrl0, ctrl1}, 24'h0);
    check("R10 soft reset keeps count", byte_cnt, 16'hAB34);
    ridx("R10 index wraps", 4'h0);
    set_idx(4'h1); rdat("R10 ifstat", 8'hFF);
    set_idx(4'h0); wdat(8'h77);
    check("R10 index 0 no effect", {byte_cnt, data_addr, wr_addr, blk_ptr},
          {16'hAB34, 16'h5678, 16'hABCD, 16'hBE11});

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule